// File: doc/BRIEF.md
# Legacy Memory Window Attribute Decoder

This block sits between a CPU's memory request path and the routing logic of a host bridge and decides, for every access that falls in the legacy region from 640 KB up to 1 MB, where the access is sent. Each access is routed to one of three places: main DRAM, the expansion bus, or nowhere. An access is dropped when it is a write to a region that has been made read-only. Addresses below 640 KB and at or above 1 MB always go to DRAM.

Software programs the routing through a small byte-addressed configuration write port. The port uses 32-bit data, byte enables and an 8-bit offset. Seven attribute bytes hold 2-bit codes for the top 64 KB block and for twelve 16 KB segments from 0xC0000 to 0xEFFFF. Each attribute byte carries two codes, in bits 1:0 and bits 5:4. A control byte decides whether the 128 KB graphics window at 0xA0000 to 0xBFFFF is backed by DRAM. One condition opens it on its own. The other opens it only while the system-management-mode input is high. A read-only byte reports the installed DRAM size. A readback port returns any configuration dword one cycle after its offset is presented.

The route for an access is registered. It appears one clock after the access is presented and uses the configuration as it stands in the cycle the access is presented. A configuration write therefore governs every access presented from the following cycle onward.

Top module: `legacy_window_decoder`

## Requirements
- R1: After synchronous reset every attribute byte reads 0x00, the window control byte (offset 0x72) reads 0x02, the size byte (offset 0x57) reads the DRAM_MB parameter divided by 8, and rt_valid, rt_dram, rt_bus and rt_drop are all 0.
- R2: A write with cfg_we=1 updates the implemented bytes of the dword at cfg_addr[7:2] whose cfg_be lane is set, with byte lane n in bits 8n+7:8n. The new value governs the decode of an access presented in the very next cycle. Writes to unimplemented bytes and to the size byte are ignored. Reading any dword returns its bytes on cfg_rd_data one cycle after cfg_rd_addr is presented, with unimplemented bytes reading 0.
- R3: Accesses at 0xF0000 to 0xFFFFF use bits 5:4 of the byte at offset 0x59 as their attribute.
- R4: Segment i (0 to 11) covers 0xC0000 + i*0x4000 for 16 KB. Its attribute is in byte 0x5A + i/2, in bits 1:0 when i is even and bits 5:4 when i is odd.
- R5: Attribute 3 routes reads and writes to DRAM. Attribute 1 routes reads to DRAM and drops writes. Attributes 0 and 2 route both reads and writes to the bus.
- R6: Accesses at 0xA0000 to 0xBFFFF go to DRAM when bit 6 of byte 0x72 is set, or when bit 3 is set and smm_active is 1. Otherwise they go to the bus, whether they are reads or writes.
- R7: Any address below 0xA0000, or with a bit above bit 19 set, routes to DRAM whatever the configuration.
- R8: One cycle after acc_valid=1, rt_valid=1 and exactly one of rt_dram, rt_bus and rt_drop is 1. When acc_valid was 0, all four are 0. Reads are never dropped.
- R9: The reset value of the size byte saturates at 0xFF when DRAM_MB/8 exceeds 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset; bits 7:2 select the dword |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data, lane n in bits 8n+7:8n |
| cfg_rd_addr | input | 8 | Readback offset; bits 7:2 select the dword |
| cfg_rd_data | output | 32 | Readback dword, one cycle after cfg_rd_addr |
| smm_active | input | 1 | System-management mode is in effect |
| acc_valid | input | 1 | A CPU memory access is presented |
| acc_addr | input | ADDR_W | Physical byte address of the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| rt_valid | output | 1 | Registered route result is valid |
| rt_dram | output | 1 | Route the access to DRAM |
| rt_bus | output | 1 | Forward the access to the expansion bus |
| rt_drop | output | 1 | Suppress the access (write to a read-only region) |

## Verification
The configuration gives neighbouring segments that share one attribute byte different codes. This checks the even/odd nibble choice and the byte index at the same time. A table of accesses then hits the first and last bytes of segments with each attribute code, as both reads and writes, so that DRAM, bus and drop outcomes each arise from more than one code. The graphics window is tried with the mode input low and high under the mode-gated bit, and again with only the unconditional bit. Addresses just below 640 KB, at exactly 1 MB, and with upper bits set above a bus-mapped segment check that the legacy decode is not applied outside its range. A write followed directly by an access, and a write to an unimplemented lane, check the timing of configuration updates and that unimplemented bytes are left alone.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
  localparam logic [7:0] SIZE_OFF  = 8'h57;
  localparam logic [7:0] ATTR_BASE = 8'h59;
  localparam logic [7:0] SMRAM_OFF = 8'h72;
  localparam logic [7:0] SMRAM_RST = 8'h02;

  typedef enum logic [1:0] {
    ROUTE_DRAM = 2'd0,
    ROUTE_BUS  = 2'd1,
    ROUTE_DROP = 2'd2
  } route_e;

  function automatic route_e apply_attr(input logic [1:0] code, input logic is_wr);
    case (code)
      2'b11:   return ROUTE_DRAM;
      2'b01:   return is_wr ? ROUTE_DROP : ROUTE_DRAM;
      default: return ROUTE_BUS;
    endcase
  endfunction
endpackage

// File: rtl/lwd_cfg_regs.sv
module lwd_cfg_regs
  import lwd_pkg::*;
#(
  parameter int ATTR_BYTES = 7,
  parameter int DRAM_MB    = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  input  logic [7:0]  cfg_rd_addr,
  output logic [31:0] cfg_rd_data,
  output logic [7:0]  attr_q [ATTR_BYTES],
  output logic [7:0]  smram_q
);
  localparam int         SIZE_UNITS = DRAM_MB / 8;
  localparam logic [7:0] SIZE_RST   = (SIZE_UNITS > 255) ? 8'hFF : 8'(SIZE_UNITS);

  function automatic logic wr_hit(input logic [7:0] off);
    return cfg_we && cfg_be[off[1:0]] && (cfg_addr[7:2] == off[7:2]);
  endfunction

  for (genvar k = 0; k < ATTR_BYTES; k++) begin : g_attr
    localparam logic [7:0] OFF = ATTR_BASE + 8'(k);
    always_ff @(posedge clk) begin
      if (rst)              attr_q[k] <= 8'h00;
      else if (wr_hit(OFF)) attr_q[k] <= cfg_wdata[OFF[1:0]*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    smram_q <= SMRAM_RST;
    else if (wr_hit(SMRAM_OFF)) smram_q <= cfg_wdata[SMRAM_OFF[1:0]*8 +: 8];
  end

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int k = 0; k < ATTR_BYTES; k++) begin
      if ((ATTR_BASE + 8'(k)) >> 2 == {2'b00, cfg_rd_addr[7:2]})
        rd_next[((ATTR_BASE + 8'(k)) & 8'h3)*8 +: 8] = attr_q[k];
    end
    if (cfg_rd_addr[7:2] == SMRAM_OFF[7:2]) rd_next[SMRAM_OFF[1:0]*8 +: 8] = smram_q;
    if (cfg_rd_addr[7:2] == SIZE_OFF[7:2])  rd_next[SIZE_OFF[1:0]*8 +: 8]  = SIZE_RST;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rd_data <= '0;
    else     cfg_rd_data <= rd_next;
  end
endmodule

// File: rtl/lwd_window_decode.sv
module lwd_window_decode
  import lwd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ATTR_BYTES = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  input  logic              smm,
  input  logic [7:0]        attr_q [ATTR_BYTES],
  input  logic [7:0]        smram,
  output route_e            route
);
  localparam int SEG_CNT = 2 * (ATTR_BYTES - 1);

  logic [1:0] seg_attr [SEG_CNT];
  for (genvar s = 0; s < SEG_CNT; s++) begin : g_seg
    if (s % 2 == 0) begin : g_lo
      assign seg_attr[s] = attr_q[1 + s/2][1:0];
    end else begin : g_hi
      assign seg_attr[s] = attr_q[1 + s/2][5:4];
    end
  end

  logic       hi_zero;
  logic       win_open;
  logic [5:0] seg_idx;

  assign hi_zero  = (addr[ADDR_W-1:20] == '0);
  assign win_open = smram[6] | (smram[3] & smm);
  assign seg_idx  = addr[19:14] - 6'h30;

  always_comb begin
    route = ROUTE_DRAM;
    if (!hi_zero || addr[19:17] < 3'b101) begin
      route = ROUTE_DRAM;
    end else if (addr[19:17] == 3'b101) begin
      route = win_open ? ROUTE_DRAM : ROUTE_BUS;
    end else if (addr[19:16] == 4'hF) begin
      route = apply_attr(attr_q[0][5:4], is_write);
    end else if (int'(seg_idx) < SEG_CNT) begin
      route = apply_attr(seg_attr[seg_idx], is_write);
    end else begin
      route = ROUTE_BUS;
    end
  end
endmodule

// File: rtl/lwd_route_reg.sv
module lwd_route_reg
  import lwd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   in_valid,
  input  route_e route,
  output logic   rt_valid,
  output logic   rt_dram,
  output logic   rt_bus,
  output logic   rt_drop
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rt_valid <= 1'b0;
      rt_dram  <= 1'b0;
      rt_bus   <= 1'b0;
      rt_drop  <= 1'b0;
    end else begin
      rt_valid <= in_valid;
      rt_dram  <= in_valid && (route == ROUTE_DRAM);
      rt_bus   <= in_valid && (route == ROUTE_BUS);
      rt_drop  <= in_valid && (route == ROUTE_DROP);
    end
  end
endmodule

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder
  import lwd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ATTR_BYTES = 7,
  parameter int DRAM_MB    = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  input  logic [7:0]        cfg_rd_addr,
  output logic [31:0]       cfg_rd_data,
  input  logic              smm_active,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              rt_valid,
  output logic              rt_dram,
  output logic              rt_bus,
  output logic              rt_drop
);
  logic [7:0] attr_q [ATTR_BYTES];
  logic [7:0] smram_q;
  route_e     route;

  lwd_cfg_regs #(.ATTR_BYTES(ATTR_BYTES), .DRAM_MB(DRAM_MB)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
    .attr_q(attr_q), .smram_q(smram_q)
  );

  lwd_window_decode #(.ADDR_W(ADDR_W), .ATTR_BYTES(ATTR_BYTES)) u_dec (
    .addr(acc_addr), .is_write(acc_write), .smm(smm_active),
    .attr_q(attr_q), .smram(smram_q), .route(route)
  );

  lwd_route_reg u_out (
    .clk(clk), .rst(rst), .in_valid(acc_valid), .route(route),
    .rt_valid(rt_valid), .rt_dram(rt_dram), .rt_bus(rt_bus), .rt_drop(rt_drop)
  );
endmodule

// File: rtl/lwd_checker.sv
module lwd_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_write,
  input logic [7:0]        smram_q,
  input logic              rt_valid,
  input logic              rt_dram,
  input logic              rt_bus,
  input logic              rt_drop
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rt_valid && !rt_dram && !rt_bus && !rt_drop);

  // R8
  one_route_chk: assert property (@(posedge clk) disable iff (rst)
    rt_valid |-> $onehot({rt_dram, rt_bus, rt_drop}));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rt_valid |-> !rt_dram && !rt_bus && !rt_drop);

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rt_valid);

  // R8
  read_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> !rt_drop);

  // R7
  outside_dram_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && (acc_addr < ADDR_W'(32'h000A_0000) || acc_addr >= ADDR_W'(32'h0010_0000)))
      |=> rt_dram);

  // R6
  window_open_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_addr >= ADDR_W'(32'h000A_0000) && acc_addr < ADDR_W'(32'h000C_0000)
      && smram_q[6]) |=> rt_dram);
endmodule

bind legacy_window_decoder lwd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_write(acc_write), .smram_q(smram_q), .rt_valid(rt_valid),
  .rt_dram(rt_dram), .rt_bus(rt_bus), .rt_drop(rt_drop)
);

// File: tb/legacy_window_decoder_tb_top.sv
module legacy_window_decoder_tb_top;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [7:0]        cfg_addr = '0;
  logic [3:0]        cfg_be = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [7:0]        cfg_rd_addr = '0;
  logic [31:0]       cfg_rd_data, sat_rd_data;
  logic              smm_active = 1'b0;
  logic              acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic              acc_write = 1'b0;
  logic              rt_valid, rt_dram, rt_bus, rt_drop;
  logic              s_valid, s_dram, s_bus, s_drop;

  int applied = 0;
  int bad = 0;

  always #5 clk = ~clk;

  legacy_window_decoder #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
    .smm_active(smm_active), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .rt_valid(rt_valid), .rt_dram(rt_dram),
    .rt_bus(rt_bus), .rt_drop(rt_drop)
  );

  legacy_window_decoder #(.ADDR_W(ADDR_W), .DRAM_MB(4096)) dut_sat_i (
    .clk(clk), .rst(rst), .cfg_we(1'b0), .cfg_addr(8'h00), .cfg_be(4'h0),
    .cfg_wdata(32'h0), .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(sat_rd_data),
    .smm_active(1'b0), .acc_valid(1'b0), .acc_addr('0), .acc_write(1'b0),
    .rt_valid(s_valid), .rt_dram(s_dram), .rt_bus(s_bus), .rt_drop(s_drop)
  );

  // route code {drop,bus,dram,valid}
  localparam logic [3:0] DR = 4'b0011, BU = 4'b0101, DP = 4'b1001;

  // {addr[31:0], write, smm, expected[3:0]}
  localparam int NV = 19;
  localparam logic [37:0] VEC [NV] = '{
    {32'h000F_0000, 1'b0, 1'b0, DR},  // R3 attr3 read
    {32'h000F_FFFF, 1'b1, 1'b0, DR},  // R3 attr3 write
    {32'h000C_0000, 1'b1, 1'b0, DR},  // R4 seg0 attr3
    {32'h000C_4000, 1'b0, 1'b0, DR},  // R5 seg1 attr1 read
    {32'h000C_7FFC, 1'b1, 1'b0, DP},  // R5 seg1 attr1 write dropped
    {32'h000C_8000, 1'b0, 1'b0, BU},  // R5 seg2 attr0
    {32'h000C_C000, 1'b1, 1'b0, BU},  // R5 seg3 attr2
    {32'h000D_0000, 1'b1, 1'b0, DP},  // R4 seg4 attr1 write
    {32'h000D_3FFF, 1'b0, 1'b0, DR},  // R4 seg4 attr1 read
    {32'h000D_4000, 1'b1, 1'b0, DR},  // R4 seg5 attr3
    {32'h000E_0000, 1'b0, 1'b0, BU},  // R4 seg8 attr0
    {32'h000E_8000, 1'b1, 1'b0, DR},  // R4 seg10 attr3
    {32'h000E_FFFF, 1'b1, 1'b0, DP},  // R4 seg11 attr1 write
    {32'h000A_0000, 1'b0, 1'b0, BU},  // R6 gated bit, mode low
    {32'h000B_FFFF, 1'b1, 1'b1, DR},  // R6 gated bit, mode high
    {32'h0000_0000, 1'b1, 1'b0, DR},  // R7 low memory
    {32'h0009_FFFF, 1'b0, 1'b0, DR},  // R7 just below window
    {32'h0010_0000, 1'b1, 1'b0, DR},  // R7 exactly 1 MB
    {32'h001C_8000, 1'b0, 1'b0, DR}   // R7 upper bit above bus segment
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    cfg_rd_addr = a;
    @(negedge clk);
    @(negedge clk);
    d = cfg_rd_data;
  endtask

  task automatic access(input string req, input logic [31:0] a, input logic wr,
                        input logic smm, input logic [3:0] exp);
    acc_valid = 1'b1; acc_addr = a; acc_write = wr; smm_active = smm;
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, {28'h0, rt_drop, rt_bus, rt_dram, rt_valid}, {28'h0, exp});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 outputs quiet, register reset values
    check("R1 outputs", {28'h0, rt_drop, rt_bus, rt_dram, rt_valid}, 32'h0);
    cfg_read(8'h54, rd); check("R1 size byte", rd, 32'h2000_0000);
    cfg_read(8'h58, rd); check("R1 attr dword 58", rd, 32'h0);
    cfg_read(8'h5C, rd); check("R1 attr dword 5C", rd, 32'h0);
    cfg_read(8'h70, rd); check("R1 window control", rd, 32'h0002_0000);
    rd = sat_rd_data; // still pointing at 0x70; re-point to size
    cfg_read(8'h54, rd); check("R9 saturated size", sat_rd_data, 32'hFF00_0000);
    // R1 attrs reset 0: legacy segment goes to bus
    @(negedge clk);
    access("R1 reset attr bus", 32'h000C_0000, 1'b0, 1'b0, BU);

    // program: 59=30 5A=13 5B=20 5C=31 5F=13 72=08; lane0 of 0x58 unimplemented
    cfg_write(8'h58, 4'hF, 32'h2013_30AA);
    cfg_write(8'h5C, 4'hF, 32'h1300_0031);
    cfg_write(8'h70, 4'h4, 32'h0008_0000);
    cfg_write(8'h54, 4'h8, 32'h5500_0000);
    cfg_read(8'h58, rd); check("R2 unimplemented lane ignored", rd, 32'h2013_3000);
    cfg_read(8'h54, rd); check("R2 size byte not writable", rd, 32'h2000_0000);
    cfg_read(8'h70, rd); check("R2 window byte written", rd, 32'h0008_0000);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      access($sformatf("vector %0d", i), VEC[i][37:6], VEC[i][5], VEC[i][4], VEC[i][3:0]);
    end

    // R8 no access, nothing asserted
    @(negedge clk);
    check("R8 idle", {28'h0, rt_drop, rt_bus, rt_dram, rt_valid}, 32'h0);

    // R2 partial byte enable: change only 0x5B (lane3), seg2 -> attr3
    cfg_write(8'h58, 4'h8, 32'h0300_0000);
    access("R2 byte-enable update seg2", 32'h000C_8000, 1'b1, 1'b0, DR);
    access("R2 lane1 untouched F region", 32'h000F_0000, 1'b1, 1'b0, DR);

    // R2 takes effect on the very next access: F region to read-only
    cfg_write(8'h58, 4'h2, 32'h0000_1000);
    access("R2 immediate effect drop", 32'h000F_8000, 1'b1, 1'b0, DP);
    access("R5 attr1 read still dram", 32'h000F_8000, 1'b0, 1'b0, DR);

    // R6 unconditional open bit with mode low
    cfg_write(8'h70, 4'h4, 32'h0040_0000);
    access("R6 open bit read", 32'h000A_0000, 1'b0, 1'b0, DR);
    access("R6 open bit write", 32'h000B_0000, 1'b1, 1'b0, DR);
    cfg_write(8'h70, 4'h4, 32'h0000_0000);
    access("R6 closed with mode high", 32'h000A_4000, 1'b1, 1'b1, BU);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule